// File: doc/BRIEF.md
# Counter-Compare Exposure PWM Controller

This block turns one row of latched 6-bit intensity levels into a drive state for every output channel of a passive-matrix display column driver. A single shared exposure counter runs once per row. Each channel compares its own level against that counter. The channel sources current until the count reaches its level. After that it either floats (tri-state) or closes its short-to-ground switch, as selected by a mode input.

A row starts with a pulse on the latch-enable input. This clears the counter and blanks every channel. After the latch pulse ends, the first rising edge on the exposure input arms the row and does not count. Each later exposure edge advances the counter by one, until the counter reaches 63. From then on, exposure edges are ignored until the next latch pulse. A binary mode turns each channel fully on or fully off for the whole pass. A standby input blanks everything and discards the pass in progress.

All inputs are sampled on one system clock, and edges on the latch and exposure inputs are found by comparing against their previous sample. An exposure or latch edge seen at clock edge k reaches the outputs at clock edge k+1. A blanking condition (latch high or standby high) clears the outputs at the same clock edge that samples it.

Top module: `expo_pwm_top`

## Requirements
- R1: After reset, every `drvOn` and `gndSw` bit is low. Both stay low until a latch pulse followed by an exposure edge arms the block.
- R2: While `latchEn` is high, every output is low and the counter is held at 0. After `latchEn` falls, the outputs stay low until the next rising edge of `expClk`.
- R3: Channel i takes its level from `levels[i*6 +: 6]` as an unsigned value. The first rising edge of `expClk` after `latchEn` falls sets `drvOn` for every channel whose level is nonzero and leaves the counter at 0.
- R4: Each later `expClk` rising edge raises the counter by exactly one. In grayscale mode a channel with level d drives while the counter is below d. It goes off when the counter equals d and stays off until the next latch pulse.
- R5: After the counter reaches 63 (the arming edge plus 63 counting edges), further `expClk` edges change no output until the next latch pulse.
- R6: With `swCtl` high, every armed channel that is not driving has `gndSw` high. This includes zero-level channels from the arming edge onward.
- R7: With `swCtl` low, an armed channel that is not driving keeps both outputs low until the counter reaches 63. At 63 every channel has `gndSw` high.
- R8: With `binMode` high, a channel with a nonzero level drives from the arming edge until the counter reaches 63, and a zero-level channel never drives. With `binMode` low the block runs in grayscale mode.
- R9: While `standby` is high, every output is low and the pass is discarded. After `standby` falls, exposure edges have no effect until a new latch pulse.
- R10: `drvOn` and `gndSw` are never high together for the same channel.
- R11: Exposure edges that arrive after reset but before any latch pulse have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples every other input |
| rstN | input | 1 | Active-low synchronous reset |
| latchEn | input | 1 | Row latch pulse; high blanks and clears, the falling edge readies the next pass |
| expClk | input | 1 | Exposure strobe; rising edges arm, then advance the counter |
| binMode | input | 1 | 1 = binary on/off, 0 = 6-bit grayscale |
| swCtl | input | 1 | 1 = short a channel as soon as it goes off; 0 = float it until the count reaches 63 |
| standby | input | 1 | High blanks every channel and abandons the pass |
| levels | input | NUM_CH*CNT_W | Packed per-channel levels, channel i at bits i*CNT_W upward |
| drvOn | output | NUM_CH | Per-channel current-source enable |
| gndSw | output | NUM_CH | Per-channel short-to-ground enable; both low means tri-state |

## Verification
The properties assume that `latchEn` and `expClk` are synchronous to `clk`, and that each high or low phase of `expClk` lasts at least two clock cycles. This lets every counting step be seen at the outputs before the next step begins. The float-until-top and single-step properties hold for any input sequence. The stimulus drives every input on the falling clock edge and holds each latch or exposure level for three cycles. `levels`, `binMode` and `swCtl` change only while the block is blanked by a latch pulse, or after a pass has finished.

// File: rtl/expo_pwm_pkg.sv
package expo_pwm_pkg;

  // One-cycle commands from the sequencer to the counter/compare datapath.
  typedef struct packed {
    logic clear;  // blank everything, zero the counter
    logic arm;    // first exposure edge of a pass
    logic step;   // advance the counter by one
  } expoStrobe_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,  // blanked, waiting for a latch to end
    PH_READY = 2'd1,  // latch done, waiting for the arming edge
    PH_RUN   = 2'd2   // pass in progress or finished
  } expoPhase_t;

endpackage

// File: rtl/expo_pwm_ctrl.sv
module expo_pwm_ctrl
  import expo_pwm_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             latchEn,
  input  logic             expClk,
  input  logic             standby,
  input  logic [CNT_W-1:0] cntVal,
  output expoStrobe_t      strobe
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic       leQ;
  logic       exQ;
  logic       exRise;
  logic       leFall;
  logic       passDone;
  expoPhase_t phase;
  expoPhase_t phaseNext;

  assign exRise   = expClk & ~exQ;
  assign leFall   = ~latchEn & leQ;
  assign passDone = (cntVal == CNT_TOP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      leQ   <= 1'b0;
      exQ   <= 1'b0;
      phase <= PH_IDLE;
    end else begin
      leQ   <= latchEn;
      exQ   <= expClk;
      phase <= phaseNext;
    end
  end

  always_comb begin
    strobe    = '0;
    phaseNext = phase;
    if (standby || latchEn) begin
      strobe.clear = 1'b1;
      phaseNext    = PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (leFall) phaseNext = PH_READY;
        end
        PH_READY: begin
          if (exRise) begin
            strobe.arm = 1'b1;
            phaseNext  = PH_RUN;
          end
        end
        PH_RUN: begin
          if (exRise && !passDone) strobe.step = 1'b1;
        end
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/expo_pwm_lane.sv
module expo_pwm_lane #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             armed,
  input  logic             atTop,
  input  logic             binMode,
  input  logic             swCtl,
  input  logic [CNT_W-1:0] cntVal,
  input  logic [CNT_W-1:0] level,
  output logic             drvOn,
  output logic             gndSw
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] effLevel;
  logic             litNext;
  logic             shortNext;

  // Binary mode reuses the comparator: nonzero acts as full scale.
  assign effLevel  = binMode ? ((level != '0) ? CNT_TOP : '0) : level;
  assign litNext   = armed & (cntVal < effLevel);
  assign shortNext = armed & ~litNext & (swCtl | atTop);

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      drvOn <= 1'b0;
      gndSw <= 1'b0;
    end else begin
      drvOn <= litNext;
      gndSw <= shortNext;
    end
  end

endmodule

// File: rtl/expo_pwm_datapath.sv
module expo_pwm_datapath
  import expo_pwm_pkg::*;
#(
  parameter int NUM_CH = 192,
  parameter int CNT_W  = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  expoStrobe_t             strobe,
  input  logic                    binMode,
  input  logic                    swCtl,
  input  logic [NUM_CH*CNT_W-1:0] levels,
  output logic [CNT_W-1:0]        cntVal,
  output logic                    armed,
  output logic [NUM_CH-1:0]       drvOn,
  output logic [NUM_CH-1:0]       gndSw
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic atTop;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      cntVal <= '0;
      armed  <= 1'b0;
    end else if (strobe.arm) begin
      cntVal <= '0;
      armed  <= 1'b1;
    end else if (strobe.step) begin
      cntVal <= cntVal + 1'b1;
    end
  end

  assign atTop = (cntVal == CNT_TOP);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    expo_pwm_lane #(
      .CNT_W(CNT_W)
    ) u_lane (
      .clk    (clk),
      .rstN   (rstN),
      .clear  (strobe.clear),
      .armed  (armed),
      .atTop  (atTop),
      .binMode(binMode),
      .swCtl  (swCtl),
      .cntVal (cntVal),
      .level  (levels[ch*CNT_W +: CNT_W]),
      .drvOn  (drvOn[ch]),
      .gndSw  (gndSw[ch])
    );
  end

endmodule

// File: rtl/expo_pwm_top.sv
module expo_pwm_top
  import expo_pwm_pkg::*;
#(
  parameter int NUM_CH = 192,
  parameter int CNT_W  = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    latchEn,
  input  logic                    expClk,
  input  logic                    binMode,
  input  logic                    swCtl,
  input  logic                    standby,
  input  logic [NUM_CH*CNT_W-1:0] levels,
  output logic [NUM_CH-1:0]       drvOn,
  output logic [NUM_CH-1:0]       gndSw
);

  expoStrobe_t      strobe;
  logic [CNT_W-1:0] expoCount;
  logic             expoArmed;

  expo_pwm_ctrl #(
    .CNT_W(CNT_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .latchEn(latchEn),
    .expClk (expClk),
    .standby(standby),
    .cntVal (expoCount),
    .strobe (strobe)
  );

  expo_pwm_datapath #(
    .NUM_CH(NUM_CH),
    .CNT_W (CNT_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .binMode(binMode),
    .swCtl  (swCtl),
    .levels (levels),
    .cntVal (expoCount),
    .armed  (expoArmed),
    .drvOn  (drvOn),
    .gndSw  (gndSw)
  );

endmodule

// File: rtl/expo_pwm_chk.sv
module expo_pwm_chk #(
  parameter int NUM_CH = 192,
  parameter int CNT_W  = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              latchEn,
  input logic              standby,
  input logic              swCtl,
  input logic [NUM_CH-1:0] drvOn,
  input logic [NUM_CH-1:0] gndSw,
  input logic [CNT_W-1:0]  expoCount,
  input logic              expoArmed
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  assert_lit_needs_arm_R1: assert property (@(posedge clk) disable iff (!rstN)
    ((|drvOn) || (|gndSw)) |-> expoArmed)
    else $error("output active while not armed");

  assert_latch_blanks_R2: assert property (@(posedge clk) disable iff (!rstN)
    (latchEn && $past(latchEn)) |-> (drvOn == '0 && gndSw == '0 && expoCount == '0))
    else $error("latch did not blank outputs and counter");

  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (expoArmed && $past(expoArmed)) |->
      ({1'b0, expoCount} == {1'b0, $past(expoCount)} ||
       {1'b0, expoCount} == {1'b0, $past(expoCount)} + 1'b1))
    else $error("counter moved by more than one");

  assert_hold_at_top_R5: assert property (@(posedge clk) disable iff (!rstN)
    (expoArmed && expoCount == CNT_TOP && !latchEn && !standby) |=>
      (expoArmed && expoCount == CNT_TOP))
    else $error("counter left its final value without a latch");

  assert_float_until_top_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!swCtl && !$past(swCtl) && (|gndSw)) |-> (expoCount == CNT_TOP))
    else $error("short switch closed before the pass finished");

  assert_standby_blank_R9: assert property (@(posedge clk) disable iff (!rstN)
    (standby && $past(standby)) |-> (drvOn == '0 && gndSw == '0))
    else $error("outputs active in standby");

  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rstN)
    (drvOn & gndSw) == '0)
    else $error("drive and short both on");

endmodule

bind expo_pwm_top expo_pwm_chk #(
  .NUM_CH(NUM_CH),
  .CNT_W (CNT_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .latchEn  (latchEn),
  .standby  (standby),
  .swCtl    (swCtl),
  .drvOn    (drvOn),
  .gndSw    (gndSw),
  .expoCount(expoCount),
  .expoArmed(expoArmed)
);

// File: tb/tb_expo_pwm_top.sv
`timescale 1ns/1ps
module tb_expo_pwm_top;

  localparam int NCH   = 4;
  localparam int CW    = 6;
  localparam int NVEC  = 12;
  localparam logic [NCH*CW-1:0] DATA_A = {6'd63, 6'd5, 6'd1, 6'd0};
  localparam logic [NCH*CW-1:0] DATA_B = {6'd3, 6'd0, 6'd62, 6'd2};

  typedef struct packed {
    logic [NCH*CW-1:0] data;
    logic              bin;
    logic              sw;
    logic [6:0]        edges;
    logic [NCH-1:0]    expDrv;
    logic [NCH-1:0]    expGnd;
  } vec_t;

  // edges counts every exposure edge after the latch, the arming edge included
  localparam vec_t VECS [NVEC] = '{
    '{DATA_A, 1'b0, 1'b1, 7'd1,  4'b1110, 4'b0001},  // R3 arm only
    '{DATA_A, 1'b0, 1'b1, 7'd2,  4'b1100, 4'b0011},  // R4 level 1 off
    '{DATA_A, 1'b0, 1'b1, 7'd6,  4'b1000, 4'b0111},  // R6 shorts after match
    '{DATA_A, 1'b0, 1'b0, 7'd6,  4'b1000, 4'b0000},  // R7 floating
    '{DATA_A, 1'b0, 1'b0, 7'd64, 4'b0000, 4'b1111},  // R7 all shorted at 63
    '{DATA_A, 1'b0, 1'b0, 7'd63, 4'b1000, 4'b0000},  // R4 count 62
    '{DATA_A, 1'b1, 1'b1, 7'd30, 4'b1110, 4'b0001},  // R8 binary mid pass
    '{DATA_A, 1'b1, 1'b0, 7'd64, 4'b0000, 4'b1111},  // R8 binary end
    '{DATA_A, 1'b0, 1'b1, 7'd70, 4'b0000, 4'b1111},  // R5 extra edges
    '{DATA_B, 1'b0, 1'b1, 7'd3,  4'b1010, 4'b0101},  // R4 mixed levels
    '{DATA_B, 1'b0, 1'b1, 7'd0,  4'b0000, 4'b0000},  // R2 latch only
    '{DATA_B, 1'b1, 1'b0, 7'd1,  4'b1011, 4'b0000}   // R8 binary arm
  };

  function automatic string tagOf(int idx);
    case (idx)
      0:       return "R3";
      2:       return "R6";
      3, 4:    return "R7";
      6, 7, 11: return "R8";
      8:       return "R5";
      10:      return "R2";
      default: return "R4";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rstN, latchEn, expClk, binMode, swCtl, standby;
  logic [NCH*CW-1:0] levels;
  logic [NCH-1:0] drvOn, gndSw;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  expo_pwm_top #(.NUM_CH(NCH), .CNT_W(CW)) dut (
    .clk(clk), .rstN(rstN), .latchEn(latchEn), .expClk(expClk),
    .binMode(binMode), .swCtl(swCtl), .standby(standby),
    .levels(levels), .drvOn(drvOn), .gndSw(gndSw)
  );

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseLatch();
    latchEn = 1'b1; waitClk(3);
    latchEn = 1'b0; waitClk(3);
  endtask

  task automatic pulseExp();
    expClk = 1'b1; waitClk(3);
    expClk = 1'b0; waitClk(3);
  endtask

  task automatic checkVec(string tag, string what, logic [NCH-1:0] act, logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; latchEn = 1'b0; expClk = 1'b0; binMode = 1'b0;
    swCtl = 1'b1; standby = 1'b0; levels = DATA_A;
    waitClk(4);
    rstN = 1'b1;
    waitClk(2);
    checkVec("R1", "reset drive", drvOn, '0);
    checkVec("R1", "reset short", gndSw, '0);

    // R11: exposure edges before any latch pulse
    repeat (3) pulseExp();
    waitClk(2);
    checkVec("R11", "pre-latch drive", drvOn, '0);
    checkVec("R11", "pre-latch short", gndSw, '0);

    for (int i = 0; i < NVEC; i++) begin
      levels  = VECS[i].data;
      binMode = VECS[i].bin;
      swCtl   = VECS[i].sw;
      waitClk(1);
      pulseLatch();
      repeat (int'(VECS[i].edges)) pulseExp();
      waitClk(2);
      checkVec(tagOf(i), "drive", drvOn, VECS[i].expDrv);
      checkVec(tagOf(i), "short", gndSw, VECS[i].expGnd);
      checkVec("R10", "overlap", drvOn & gndSw, '0);
    end

    // R2: latch in the middle of a pass
    levels = DATA_A; binMode = 1'b0; swCtl = 1'b1;
    pulseLatch();
    repeat (3) pulseExp();
    waitClk(2);
    checkVec("R4", "mid pass drive", drvOn, 4'b1100);
    latchEn = 1'b1;
    waitClk(3);
    checkVec("R2", "latch high drive", drvOn, '0);
    checkVec("R2", "latch high short", gndSw, '0);
    latchEn = 1'b0;
    waitClk(3);
    checkVec("R2", "after latch drive", drvOn, '0);
    checkVec("R2", "after latch short", gndSw, '0);
    pulseExp();
    waitClk(2);
    checkVec("R3", "rearm drive", drvOn, 4'b1110);
    checkVec("R6", "rearm short", gndSw, 4'b0001);

    // R9: standby in the middle of a pass
    pulseExp();
    standby = 1'b1;
    waitClk(3);
    checkVec("R9", "standby drive", drvOn, '0);
    checkVec("R9", "standby short", gndSw, '0);
    standby = 1'b0;
    waitClk(3);
    repeat (2) pulseExp();
    waitClk(2);
    checkVec("R9", "post standby drive", drvOn, '0);
    checkVec("R9", "post standby short", gndSw, '0);
    pulseLatch();
    pulseExp();
    waitClk(2);
    checkVec("R9", "relatch drive", drvOn, 4'b1110);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule